// File: doc/BRIEF.md
# Bidirectional Pin Port Controller with Weak Pullups

This block controls one port of eight general-purpose pins through a small register interface. Software sets a direction bit for each pin. A pin set as an output is driven push-pull with its stored data bit. A pin set as an input either gets a weak pullup or floats, and the data bit for that pin chooses which. The pin levels pass through a two-flop synchronizer and can be read back at their own address. A fixed 16-bit revision word can also be read.

The block has two reset inputs. The general reset clears every register. The power-fail reset clears only the output-data register and the synchronizer, and it keeps the direction settings. While either reset is low, register writes are ignored.

Only the low six data bits are implemented (parameter `DATA_W`). The upper data bits are reserved.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After the general reset, the direction and data registers read 0, every `pin_oe` and `pin_pu` bit is 0, and every `pin_out` bit is 0.
- R2: A pin whose direction bit is 1 has `pin_oe` = 1 and `pin_out` equal to its data bit. A pin whose direction bit is 0 has `pin_out` = 0.
- R3: A pin whose direction bit is 0 and whose data bit is 1 has `pin_pu` = 1 and `pin_oe` = 0.
- R4: The following pins have `pin_pu` = 0:
  - a pin whose direction bit is 0 and whose data bit is 0 (it is three-state, and also has `pin_oe` = 0);
  - any pin whose direction bit is 1.
- R5: A power-fail reset pulse (`pfail_rst_n` low) clears the data register to 0 and leaves the direction register unchanged.
- R6: The general reset (`rst_n` low) clears both the direction register and the data register, even when they held non-zero values.
- R7: Writing the direction register (address 0) never changes the stored data register.
- R8: The data register (address 1) stores only bits 5:0. Bits 7:6 ignore writes and read as 0, and `pin_out`[7:6] stay 0.
- R9: A read of address 3 returns the revision word: the code `REV_CODE` (default A1h) in bits 7:0 and 00h in bits 15:8. Writes to address 3 leave it unchanged.
- R10: A read of address 2 returns `pin_in` through two flops. A change on `pin_in` is not visible after the first rising edge and is visible after the second.
- R11: A write with `wr_en` = 1 takes effect at the next rising edge. Reads are combinational from `addr`. Addresses 0 and 1 return the stored register contents, not the pin levels. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | General reset, active low, asynchronous |
| pfail_rst_n | input | 1 | Power-fail reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value driven on pins that are outputs |
| pin_oe | output | 8 | Output enable for each pin |
| pin_pu | output | 8 | Weak pullup enable for each pin |

## Verification
The hardest state to reach is a power-fail reset that arrives after both registers hold non-zero values. The test must show that the direction bits survive while the data bits clear. It must also show that the pins' drive and pullup outputs then follow that mixed state.

The bench first writes distinct patterns to both registers and pulses only `pfail_rst_n`. It then checks the readback and the pin outputs bit by bit. It also attempts a write during the pulse and checks that the write was dropped.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_W = 8;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR  = 3'd0,
        A_DATA = 3'd1,
        A_PIN  = 3'd2,
        A_REV  = 3'd3
    } gpio_addr_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int W  = GPIO_W,
    parameter int DW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_all_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata_dir,
    input  logic [DW-1:0]     wdata_dat,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dout
);
    logic [W-1:0]  dir_d;
    logic [DW-1:0] dat_d, dat_q;
    logic          wr_ok;

    // Writes are blocked while either reset is low.
    assign wr_ok = wr_en && rst_n && rst_all_n;

    always_comb begin
        dir_d = dir_q;
        dat_d = dat_q;
        if (wr_ok && addr == A_DIR)  dir_d = wdata_dir;
        if (wr_ok && addr == A_DATA) dat_d = wdata_dat;
    end

    // Direction register: general reset only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    // Data register: cleared by either reset.
    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) dat_q <= '0;
        else            dat_q <= dat_d;
    end

    generate
        if (DW < W) begin : g_pad
            assign dout = {{(W-DW){1'b0}}, dat_q};
        end else begin : g_full
            assign dout = dat_q;
        end
    endgenerate

    p_dir_write_r11: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && addr == A_DIR) |=> dir_q == $past(wdata_dir));
    p_dir_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && addr == A_DIR) |=> $stable(dout));
    p_dir_survives_pfail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_all_n && $past(!rst_all_n)) |-> $stable(dir_q));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic         clk,
    input  logic         rst_all_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign pin_sync = st_q.s2;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dout,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pin_oe[i]  = dir[i];
        assign pin_out[i] = dir[i] & dout[i];
        assign pin_pu[i]  = ~dir[i] & dout[i];
    end

    always_comb begin
        p_pu_off_when_driving_r4: assert ((pin_pu & pin_oe) == '0);
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int         DATA_W   = 6,
    parameter logic [7:0] REV_CODE = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic [GPIO_W-1:0] pin_pu
);
    localparam int PAD_W = BUS_W - GPIO_W;

    logic              rst_all_n;
    logic [GPIO_W-1:0] dir_q, dout, pin_sync;
    logic              unused_wdata;

    assign rst_all_n    = rst_n & pfail_rst_n;
    assign unused_wdata = ^wdata[BUS_W-1:GPIO_W];

    gpio_regfile #(.W(GPIO_W), .DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_all_n (rst_all_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata_dir (wdata[GPIO_W-1:0]),
        .wdata_dat (wdata[DATA_W-1:0]),
        .dir_q     (dir_q),
        .dout      (dout)
    );

    gpio_sync #(.W(GPIO_W)) u_sync (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .pin_in    (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_pad_ctrl #(.W(GPIO_W)) u_pad (
        .dir     (dir_q),
        .dout    (dout),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    always_comb begin
        case (addr)
            A_DIR:   rdata = {{PAD_W{1'b0}}, dir_q};
            A_DATA:  rdata = {{PAD_W{1'b0}}, dout};
            A_PIN:   rdata = {{PAD_W{1'b0}}, pin_sync};
            A_REV:   rdata = {8'h00, REV_CODE};
            default: rdata = '0;
        endcase
    end

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
        (addr == A_DATA) |-> rdata[BUS_W-1:DATA_W] == '0);
    p_rev_fixed_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
        (addr == A_REV) |-> rdata == {8'h00, REV_CODE});
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0, pfail_rst_n = 1, wr_en = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0, rdata;
    logic [7:0]  pin_in = 0, pin_out, pin_oe, pin_pu;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pfail_rst_n(pfail_rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        addr = a; #1; chk(req, rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 dir", 3'd0, 16'h0000);
        rd_chk("R1 data", 3'd1, 16'h0000);
        chk("R1 oe", {8'h0, pin_oe}, 16'h0);
        chk("R1 pu", {8'h0, pin_pu}, 16'h0);
        chk("R1 out", {8'h0, pin_out}, 16'h0);
    endtask

    task automatic t_modes;
        wr(3'd1, 16'h0035);
        wr(3'd0, 16'h000F);
        chk("R2 oe", {8'h0, pin_oe}, 16'h000F);
        chk("R2 out", {8'h0, pin_out}, 16'h0005);
        chk("R3 pu", {8'h0, pin_pu}, 16'h0030);
        chk("R4 tri/no pu", {8'h0, pin_pu & ~8'h30}, 16'h0);
        rd_chk("R11 dir readback", 3'd0, 16'h000F);
        rd_chk("R11 data readback", 3'd1, 16'h0035);
    endtask

    task automatic t_dir_keeps_data;
        wr(3'd0, 16'h00F0);
        rd_chk("R7 data after dir write", 3'd1, 16'h0035);
        chk("R2 out after dir flip", {8'h0, pin_out}, 16'h0030);
        chk("R4 pu with outputs", {8'h0, pin_pu}, 16'h0005);
    endtask

    task automatic t_reserved;
        wr(3'd1, 16'hFFFF);
        rd_chk("R8 data reserved", 3'd1, 16'h003F);
        wr(3'd0, 16'h00FF);
        chk("R8 pin_out high bits", {8'h0, pin_out}, 16'h003F);
    endtask

    task automatic t_rev_unmapped;
        wr(3'd3, 16'h1234);
        rd_chk("R9 revision", 3'd3, 16'h00A1);
        for (int a = 4; a < 8; a++) rd_chk("R11 unmapped", 3'(a), 16'h0000);
    endtask

    task automatic t_sync;
        @(negedge clk); pin_in = 8'h5A;
        rd_chk("R11 data not pins", 3'd1, 16'h003F);
        @(negedge clk); rd_chk("R10 one edge", 3'd2, 16'h0000);
        @(negedge clk); rd_chk("R10 two edges", 3'd2, 16'h005A);
    endtask

    task automatic t_write_timing;
        @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 16'h0081; #1;
        chk("R11 before edge", rdata, 16'h00FF);
        @(negedge clk); wr_en = 0; #1;
        chk("R11 after edge", rdata, 16'h0081);
    endtask

    task automatic t_pfail;
        wr(3'd1, 16'h0012);
        @(negedge clk); pfail_rst_n = 0; wr_en = 1; addr = 3'd0; wdata = 16'h0000;
        @(negedge clk); wr_en = 0; pfail_rst_n = 1;
        rd_chk("R5 dir kept", 3'd0, 16'h0081);
        rd_chk("R5 data cleared", 3'd1, 16'h0000);
        chk("R5 pins", {pin_oe, pin_pu}, 16'h8100);
    endtask

    task automatic t_gen_reset;
        wr(3'd1, 16'h0021);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_chk("R6 dir cleared", 3'd0, 16'h0000);
        rd_chk("R6 data cleared", 3'd1, 16'h0000);
        chk("R6 oe", {8'h0, pin_oe}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_modes();
        t_dir_keeps_data();
        t_reserved();
        t_rev_unmapped();
        t_sync();
        t_write_timing();
        t_pfail();
        t_gen_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule